// File: doc/BRIEF.md
# Console Character Register Block

This block is a bus slave that exposes a character input channel and a character output channel to a processor as four 32-bit registers at consecutive word addresses. Each channel has a control word and a data word. The control word carries a ready flag, set by the device side and read-only to software, and an interrupt-enable flag that software can write.

Reading the input data word consumes the pending byte. Writing the output data word hands a byte to the display. Both accesses clear that channel's ready flag as a side effect.

The device side consists of simple handshake ports. A byte source presents a byte with a one-cycle valid strobe. A byte sink receives a one-cycle launch pulse and later answers with a one-cycle done strobe. A level-sensitive interrupt request combines the two channels, so software can either poll or take interrupts.

Top module: `console_mmio_regs`

## Requirements
- R1: After reset, the input ready flag is 0, the output ready flag is 1, both enable flags are 0, `irq_o` is 0 and `disp_vld_o` is 0.
- R2: The register index is taken from address bits 3:2: input control, then input data, then output control, then output data, at base 0xFFFF0000. An address outside these four words, or with bits 1:0 not zero, reads as 0, and accesses to it change nothing.
- R3: In both control words, bit 0 is the ready flag, bit 1 is the enable flag, and all other bits read 0. A control write loads the enable flag from write-data bit 1 and leaves ready unchanged.
- R4: A byte strobed on `kbd_vld_i` sets input ready on the next cycle. The byte then reads from bits 7:0 of the input data word, and bits 31:8 read 0.
- R5: A read of the input data word clears input ready on the next cycle. If a byte arrives in the same cycle, ready stays 1 and the data word holds the new byte.
- R6: A byte arriving while input ready is already 1 overwrites the data word, and ready stays 1.
- R7: A write to the output data word clears output ready on the next cycle. On that same next cycle `disp_vld_o` pulses for one cycle with `disp_byte_o` equal to write-data bits 7:0. The output data word then reads back that byte.
- R8: A `disp_done_i` strobe sets output ready on the next cycle. A write to the output data word in the same cycle takes precedence, and ready ends at 0.
- R9: `irq_o` is 1 exactly when (input ready AND input enable) OR (output ready AND output enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 32 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register (combinational) |
| kbd_vld_i | input | 1 | Input byte strobe |
| kbd_byte_i | input | 8 | Input byte |
| disp_vld_o | output | 1 | One-cycle launch pulse to the display |
| disp_byte_o | output | 8 | Byte for the display |
| disp_done_i | input | 1 | Display has accepted the byte |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a byte arriving in the very cycle that software reads the input data word. The other is a done strobe landing together with a new output write. In both cases the set and the clear compete for the same flag.

Directed sequences place each collision exactly. The input collision is also exercised with ready already set, which covers the overwrite case. A long seeded random run then drives byte strobes, done strobes and bus accesses independently. This includes stray and misaligned addresses, so the collisions recur in many combinations with the enable flags. Every read value and the interrupt level are compared against a cycle-level model.

// File: rtl/console_mmio_pkg.sv
package console_mmio_pkg;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned CHAR_W   = 8;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned RDY_BIT  = 0;
  localparam int unsigned IE_BIT   = 1;

  typedef enum logic [1:0] {
    REG_IN_CTRL  = 2'd0,
    REG_IN_DATA  = 2'd1,
    REG_OUT_CTRL = 2'd2,
    REG_OUT_DATA = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/console_addr_dec.sv
module console_addr_dec #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_REGS  = 4,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o
);
  localparam int unsigned IDX_W  = $clog2(NUM_REGS);
  localparam int unsigned SPAN_W = IDX_W + 2;

  logic hit;
  logic [IDX_W-1:0] idx;

  assign hit = (addr_i[ADDR_W-1:SPAN_W] == BASE[ADDR_W-1:SPAN_W]) && (addr_i[1:0] == 2'b00);
  assign idx = addr_i[SPAN_W-1:2];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel_o[g] = req_i && hit && (idx == IDX_W'(g));
  end

  // R2
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  // R2
  sel_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (sel_o == '0));
endmodule

// File: rtl/console_in_chan.sv
module console_in_chan #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [CHAR_W-1:0] byte_i,
  input  logic              rd_clr_i,
  input  logic              ie_wr_i,
  input  logic              ie_val_i,
  output logic              rdy_o,
  output logic              ie_o,
  output logic [CHAR_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_o  <= 1'b0;
      ie_o   <= 1'b0;
      data_o <= '0;
    end else begin
      // arrival beats a same-cycle consuming read
      if (byte_vld_i) begin
        rdy_o  <= 1'b1;
        data_o <= byte_i;
      end else if (rd_clr_i) begin
        rdy_o  <= 1'b0;
      end
      if (ie_wr_i) ie_o <= ie_val_i;
    end
  end

  // R4
  in_arrive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i |=> rdy_o && (data_o == $past(byte_i)));
  // R5
  in_consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !byte_vld_i) |=> !rdy_o);
  // R3
  in_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_vld_i && !rd_clr_i) |=> $stable(rdy_o) && $stable(data_o));
endmodule

// File: rtl/console_out_chan.sv
module console_out_chan #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CHAR_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic              ie_wr_i,
  input  logic              ie_val_i,
  output logic              rdy_o,
  output logic              ie_o,
  output logic [CHAR_W-1:0] data_o,
  output logic              disp_vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_o      <= 1'b1;
      ie_o       <= 1'b0;
      data_o     <= '0;
      disp_vld_o <= 1'b0;
    end else begin
      disp_vld_o <= wr_i;
      // new write beats a same-cycle done
      if (wr_i) begin
        rdy_o  <= 1'b0;
        data_o <= wdata_i;
      end else if (done_i) begin
        rdy_o  <= 1'b1;
      end
      if (ie_wr_i) ie_o <= ie_val_i;
    end
  end

  // R7
  out_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !rdy_o && disp_vld_o && (data_o == $past(wdata_i)));
  // R7
  out_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> !disp_vld_o);
  // R8
  out_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !wr_i) |=> rdy_o);
endmodule

// File: rtl/console_mmio_regs.sv
module console_mmio_regs
  import console_mmio_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic              kbd_vld_i,
  input  logic [CHAR_W-1:0] kbd_byte_i,
  output logic              disp_vld_o,
  output logic [CHAR_W-1:0] disp_byte_o,
  input  logic              disp_done_i,
  output logic              irq_o
);
  logic [NUM_REGS-1:0] sel;
  logic in_rdy, in_ie, out_rdy, out_ie;
  logic [CHAR_W-1:0] in_data, out_data;
  logic rd, wr;

  assign rd = !bus_we_i;
  assign wr = bus_we_i;

  console_addr_dec #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .BASE(BASE)) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (bus_req_i),
    .addr_i(bus_addr_i),
    .sel_o (sel)
  );

  console_in_chan #(.CHAR_W(CHAR_W)) u_in (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_vld_i(kbd_vld_i),
    .byte_i    (kbd_byte_i),
    .rd_clr_i  (sel[REG_IN_DATA] && rd),
    .ie_wr_i   (sel[REG_IN_CTRL] && wr),
    .ie_val_i  (bus_wdata_i[IE_BIT]),
    .rdy_o     (in_rdy),
    .ie_o      (in_ie),
    .data_o    (in_data)
  );

  console_out_chan #(.CHAR_W(CHAR_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (sel[REG_OUT_DATA] && wr),
    .wdata_i   (bus_wdata_i[CHAR_W-1:0]),
    .done_i    (disp_done_i),
    .ie_wr_i   (sel[REG_OUT_CTRL] && wr),
    .ie_val_i  (bus_wdata_i[IE_BIT]),
    .rdy_o     (out_rdy),
    .ie_o      (out_ie),
    .data_o    (out_data),
    .disp_vld_o(disp_vld_o)
  );

  assign disp_byte_o = out_data;

  always_comb begin
    bus_rdata_o = '0;
    if (sel[REG_IN_CTRL]) begin
      bus_rdata_o[RDY_BIT] = in_rdy;
      bus_rdata_o[IE_BIT]  = in_ie;
    end
    if (sel[REG_IN_DATA])  bus_rdata_o[CHAR_W-1:0] = in_data;
    if (sel[REG_OUT_CTRL]) begin
      bus_rdata_o[RDY_BIT] = out_rdy;
      bus_rdata_o[IE_BIT]  = out_ie;
    end
    if (sel[REG_OUT_DATA]) bus_rdata_o[CHAR_W-1:0] = out_data;
  end

  assign irq_o = (in_rdy && in_ie) || (out_rdy && out_ie);

  // R9
  irq_in_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kbd_vld_i && in_ie && !(sel[REG_IN_CTRL] && wr)) |=> irq_o);
  // R3
  ctrl_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel[REG_IN_CTRL] || sel[REG_OUT_CTRL]) |-> (bus_rdata_o[BUS_W-1:2] == '0));
endmodule

// File: tb/tb_console_mmio_regs.sv
`timescale 1ns/1ps
module tb_console_mmio_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, we = 0, kv = 0, done = 0;
  logic [31:0] addr = '0, wdata = '0;
  logic [7:0] kb = '0;
  logic [31:0] rdata;
  logic dv, irq;
  logic [7:0] db;

  int checks = 0, fails = 0;
  bit m_in_rdy, m_in_ie, m_out_rdy, m_out_ie, m_dv;
  logic [7:0] m_in_data, m_out_data;

  always #2 clk = ~clk;

  console_mmio_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .kbd_vld_i(kv), .kbd_byte_i(kb), .disp_vld_o(dv), .disp_byte_o(db),
    .disp_done_i(done), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_hit(logic [31:0] a);
    return (a[31:4] == 28'hFFFF000) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] exp_read(logic [31:0] a);
    if (!is_hit(a)) return 32'h0;
    case (a[3:2])
      2'd0: return {30'h0, m_in_ie, m_in_rdy};
      2'd1: return {24'h0, m_in_data};
      2'd2: return {30'h0, m_out_ie, m_out_rdy};
      default: return {24'h0, m_out_data};
    endcase
  endfunction

  // one bus cycle: drive at negedge, check before the next edge, advance the model
  task automatic step(string tag, bit r, bit w, logic [31:0] a, logic [31:0] d,
                      bit k, logic [7:0] kbyte, bit dn);
    bit h;
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; kv = k; kb = kbyte; done = dn;
    #1;
    if (r && !w) chk(tag, rdata, exp_read(a));
    chk("R9 irq", {31'h0, irq}, {31'h0, (m_in_rdy && m_in_ie) || (m_out_rdy && m_out_ie)});
    chk("R7 disp_vld", {31'h0, dv}, {31'h0, m_dv});
    if (m_dv) chk("R7 disp_byte", {24'h0, db}, {24'h0, m_out_data});
    h = r && is_hit(a);
    if (k) begin m_in_rdy = 1; m_in_data = kbyte; end
    else if (h && !w && a[3:2] == 2'd1) m_in_rdy = 0;
    if (h && w && a[3:2] == 2'd0) m_in_ie = d[1];
    if (h && w && a[3:2] == 2'd2) m_out_ie = d[1];
    m_dv = h && w && a[3:2] == 2'd3;
    if (m_dv) begin m_out_rdy = 0; m_out_data = d[7:0]; end
    else if (dn) m_out_rdy = 1;
  endtask

  task automatic rd(string tag, logic [31:0] a);
    step(tag, 1, 0, a, 32'h0, 0, 8'h0, 0);
  endtask
  task automatic wr(logic [31:0] a, logic [31:0] d);
    step("wr", 1, 1, a, d, 0, 8'h0, 0);
  endtask
  task automatic idle(bit k, logic [7:0] b, bit dn);
    step("idle", 0, 0, 32'h0, 32'h0, k, b, dn);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_in_rdy = 0; m_in_ie = 0; m_out_rdy = 1; m_out_ie = 0; m_dv = 0;
    m_in_data = 0; m_out_data = 0;
    void'($urandom(32'hC0DE_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 disp_vld", {31'h0, dv}, 32'h0);
    rd("R1 in_ctrl", 32'hFFFF_0000);
    rd("R1 out_ctrl", 32'hFFFF_0008);
    rd("R1 in_data", 32'hFFFF_0004);
    rd("R1 out_data", 32'hFFFF_000C);
    // R4 arrival
    idle(1, 8'h41, 0);
    rd("R4 in_ctrl", 32'hFFFF_0000);
    chk("R4 in_ctrl lit", rdata, 32'h1);
    rd("R4 in_data", 32'hFFFF_0004);
    chk("R4 in_data lit", rdata, 32'h41);
    rd("R5 cleared", 32'hFFFF_0000);
    // R6 overwrite
    idle(1, 8'h11, 0);
    idle(1, 8'h22, 0);
    rd("R6 in_data", 32'hFFFF_0004);
    // R5 collision: read and arrival together
    idle(1, 8'h33, 0);
    step("R5 collide", 1, 0, 32'hFFFF_0004, 0, 1, 8'h5A, 0);
    rd("R5 ready kept", 32'hFFFF_0000);
    rd("R5 new byte", 32'hFFFF_0004);
    // R3 control writes, ready read-only
    idle(1, 8'h77, 0);
    wr(32'hFFFF_0000, 32'hFFFF_FFFE);
    rd("R3 in_ctrl ie", 32'hFFFF_0000);
    chk("R3 in_ctrl lit", rdata, 32'h3);
    wr(32'hFFFF_0000, 32'h0000_0001);
    rd("R3 ready untouched", 32'hFFFF_0000);
    wr(32'hFFFF_0008, 32'h2);
    rd("R9 out irq", 32'hFFFF_0008);
    // R7 launch
    wr(32'hFFFF_000C, 32'h1234_5678);
    rd("R7 out_ctrl", 32'hFFFF_0008);
    rd("R7 out_data", 32'hFFFF_000C);
    chk("R7 out_data lit", rdata, 32'h78);
    // R8 done, then collision
    idle(0, 8'h0, 1);
    rd("R8 ready back", 32'hFFFF_0008);
    step("R8 collide", 1, 1, 32'hFFFF_000C, 32'h9C, 0, 8'h0, 1);
    rd("R8 write wins", 32'hFFFF_0008);
    // R2 stray addresses
    wr(32'hFFFF_0010, 32'hFFFF_FFFF);
    wr(32'hFFFF_0002, 32'hFFFF_FFFF);
    wr(32'h0000_000C, 32'hFFFF_FFFF);
    rd("R2 past end", 32'hFFFF_0010);
    rd("R2 misaligned", 32'hFFFF_0006);
    rd("R2 other page", 32'h0000_0004);
    rd("R2 state intact", 32'hFFFF_0008);
    rd("R2 data intact", 32'hFFFF_000C);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a, d;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 8) ? (32'hFFFF_0000 | ($urandom_range(0, 3) << 2))
        : (sel == 8) ? (32'hFFFF_0000 | $urandom_range(0, 31)) : $urandom;
      d = $urandom;
      step("R2/R3/R5/R6 rand", $urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1, a, d,
           $urandom_range(0, 3) == 0, 8'($urandom), $urandom_range(0, 3) == 0);
    end
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule